// File: doc/BRIEF.md
# Serial Transmit Framer with Selectable Parity

This block turns one byte at a time into an asynchronous serial frame on a single transmit line. A producer offers a byte with a valid/ready handshake. The framer starts a frame only when its serializer is idle. A one-cycle baud tick enable paces the output, and each bit on the line lasts a fixed number of these ticks.

The parity enable and the two-bit parity select choose whether a parity bit follows the data, and which rule sets it. The rule is odd, even, a constant one or a constant zero. Both settings are captured when a byte is accepted, so the producer may change them while a frame is on the line.

A break input forces the line low at once, even in the middle of a frame. While break is high no new byte is accepted. Once break is released, the framer accepts bytes again from the idle state.

Top module: `uart_txframer`

## Requirements
- R1: After reset the line `txd` is 1 and `in_ready` is 1.
- R2: A frame is a start bit of 0, then the 8 data bits least significant first, then the optional parity bit, then a stop bit of 1. Each bit lasts 16 cycles in which `tick` is high. Cycles without `tick` do not advance the frame.
- R3: With `par_en` = 0 no parity bit is sent, so the stop bit comes directly after data bit 7.
- R4: With `par_en` = 1 and `par_sel` = 0 (odd), the parity bit makes the count of ones in the data plus parity odd.
- R5: With `par_en` = 1 and `par_sel` = 1 (even), the parity bit makes the count of ones in the data plus parity even.
- R6: With `par_en` = 1 and `par_sel` = 2, the parity bit is always 1.
- R7: With `par_en` = 1 and `par_sel` = 3, the parity bit is always 0.
- R8: While `brk` is 1, `txd` is 0 in the same cycle, whatever state the serializer is in.
- R9: While `brk` is 1, `in_ready` is 0 and no byte is accepted. After `brk` falls, a byte is accepted from idle and sent as a full frame.
- R10: `par_en` and `par_sel` are captured in the cycle the byte is accepted. Changing them later does not alter the frame in progress.
- R11: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when the serializer is idle, so it stays 0 from acceptance until the stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Baud tick enable, one cycle wide |
| par_en | input | 1 | Parity enable |
| par_sel | input | 2 | Parity rule: 0 odd, 1 even, 2 constant one, 3 constant zero |
| brk | input | 1 | Break: forces the line low and blocks new frames |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Framer can accept a byte |
| in_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output line, idles at 1 |

## Verification
The assertions assume that reset is asserted at the start and that `in_data`, `par_en` and `par_sel` are defined in any cycle where a byte can be accepted. They also assume that `tick` lasts one cycle at a time, so that bit lengths can be counted in ticks. The stimulus changes every input only on the falling clock edge. It pulses `tick` for one cycle in every three. It holds the data and the parity settings steady from the point where `in_valid` is raised until the byte is accepted, and changes the parity settings only after acceptance.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

   typedef enum logic [1:0] {
      PM_ODD  = 2'd0,
      PM_EVEN = 2'd1,
      PM_ONE  = 2'd2,
      PM_ZERO = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_START,
      SQ_DATA,
      SQ_PAR,
      SQ_STOP
   } seq_state_e;

endpackage

// File: rtl/uatx_parity.sv
module uatx_parity
   import uatx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   input  par_mode_e         mode,
   output logic              pbit
);

   logic [DATA_W-1:0] xr_chain;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("uatx_parity: DATA_W must be at least 1");
      end
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_xr
         if (gi == 0) begin : g_first
            assign xr_chain[gi] = data[gi];
         end else begin : g_next
            assign xr_chain[gi] = xr_chain[gi-1] ^ data[gi];
         end
      end
   endgenerate

   always_comb begin
      unique case (mode)
         PM_ODD:  pbit = ~xr_chain[DATA_W-1];
         PM_EVEN: pbit = xr_chain[DATA_W-1];
         PM_ONE:  pbit = 1'b1;
         default: pbit = 1'b0;
      endcase
   end

   always_comb begin
      if (mode == PM_ODD)  assert_odd_total_R4   : assert ((^{data, pbit}) == 1'b1);
      if (mode == PM_EVEN) assert_even_total_R5  : assert ((^{data, pbit}) == 1'b0);
      if (mode == PM_ONE)  assert_forced_one_R6  : assert (pbit == 1'b1);
      if (mode == PM_ZERO) assert_forced_zero_R7 : assert (pbit == 1'b0);
   end

endmodule

// File: rtl/uatx_bitclk.sv
module uatx_bitclk #(
   parameter int OVERSAMPLE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic bit_end
);

   localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

   generate
      if (OVERSAMPLE < 2) begin : g_bad_os
         $error("uatx_bitclk: OVERSAMPLE must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign bit_end = run && tick && (cnt == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= bit_end ? '0 : cnt + 1'b1;
      end
   end

   assert_hold_without_tick_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(tick)) |-> $stable(cnt));

endmodule

// File: rtl/uatx_seq.sv
module uatx_seq
   import uatx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] data,
   input  logic              par_en,
   input  logic              pbit_in,
   input  logic              bit_end,
   output logic              busy,
   output logic              line_bit
);

   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   seq_state_e        state;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;
   logic              lat_en;
   logic              lat_pbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         shreg    <= '0;
         idx      <= '0;
         lat_en   <= 1'b0;
         lat_pbit <= 1'b0;
      end else if (state == SQ_IDLE) begin
         if (accept) begin
            state    <= SQ_START;
            shreg    <= data;
            idx      <= '0;
            lat_en   <= par_en;
            lat_pbit <= pbit_in;
         end
      end else if (bit_end) begin
         unique case (state)
            SQ_START: state <= SQ_DATA;
            SQ_DATA: begin
               shreg <= shreg >> 1;
               if (idx == IDX_LAST) begin
                  state <= lat_en ? SQ_PAR : SQ_STOP;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            SQ_PAR:  state <= SQ_STOP;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign busy = (state != SQ_IDLE);

   always_comb begin
      unique case (state)
         SQ_START: line_bit = 1'b0;
         SQ_DATA:  line_bit = shreg[0];
         SQ_PAR:   line_bit = lat_pbit;
         default:  line_bit = 1'b1;
      endcase
   end

   assert_start_after_accept_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !busy) |=> (busy && !line_bit));

   assert_stop_before_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(line_bit));

   assert_settings_held_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(lat_en) && $stable(lat_pbit)));

endmodule

// File: rtl/uart_txframer.sv
module uart_txframer
   import uatx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              par_en,
   input  logic [1:0]        par_sel,
   input  logic              brk,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              txd
);

   logic busy;
   logic line_bit;
   logic bit_end;
   logic pbit;
   logic accept;

   assign in_ready = !busy && !brk;
   assign accept   = in_valid && in_ready;
   assign txd      = brk ? 1'b0 : line_bit;

   uatx_parity #(.DATA_W(DATA_W)) u_parity (
      .data (in_data),
      .mode (par_mode_e'(par_sel)),
      .pbit (pbit)
   );

   uatx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) u_bitclk (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .tick    (tick),
      .bit_end (bit_end)
   );

   uatx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .data     (in_data),
      .par_en   (par_en),
      .pbit_in  (pbit),
      .bit_end  (bit_end),
      .busy     (busy),
      .line_bit (line_bit)
   );

   assert_no_accept_in_break_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (brk && !busy) |=> !busy);

   assert_busy_blocks_ready_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

endmodule

// File: tb/uart_txframer_tb.sv
module uart_txframer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       par_en = 1'b0;
   logic [1:0] par_sel = 2'd0;
   logic       brk = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_data = 8'h00;
   logic       txd;

   int errors = 0;
   int checks = 0;
   int ph = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      ph   <= (ph == 2) ? 0 : ph + 1;
      tick <= (ph == 2);
   end

   uart_txframer u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .par_en   (par_en),
      .par_sel  (par_sel),
      .brk      (brk),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .txd      (txd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      int k = 0;
      while (k < n) begin
         @(posedge clk);
         if (tick) k++;
      end
      @(negedge clk);
   endtask

   function automatic logic exp_parity(input logic [7:0] d, input logic [1:0] sel);
      case (sel)
         2'd0: return ~(^d);
         2'd1: return ^d;
         2'd2: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // Offer a byte and return at the falling edge just after acceptance.
   task automatic push(input logic [7:0] d);
      in_data  = d;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Check a whole frame bit by bit, starting right after acceptance.
   task automatic check_frame(input logic [7:0] d, input logic en, input logic pb,
                              input string req);
      logic exp_bits [0:10];
      int   nbits = en ? 11 : 10;
      exp_bits[0] = 1'b0;
      for (int i = 0; i < 8; i++) exp_bits[i+1] = d[i];
      exp_bits[9]  = en ? pb : 1'b1;
      exp_bits[10] = 1'b1;
      wait_ticks(8);
      check({req, " R2 start"}, txd, exp_bits[0]);
      check("R11 ready low in frame", in_ready, 1'b0);
      for (int i = 1; i < nbits; i++) begin
         wait_ticks(16);
         check($sformatf("%s R2 bit%0d", req, i), txd, exp_bits[i]);
      end
      wait_ticks(8);
      check({req, " R11 ready back"}, in_ready, 1'b1);
      check({req, " R1 idle line"}, txd, 1'b1);
   endtask

   task automatic t_reset();
      check("R1 txd after reset", txd, 1'b1);
      check("R1 ready after reset", in_ready, 1'b1);
   endtask

   task automatic t_frame(input logic [7:0] d, input logic en, input logic [1:0] sel,
                          input string req);
      par_en  = en;
      par_sel = sel;
      push(d);
      check_frame(d, en, exp_parity(d, sel), req);
   endtask

   task automatic t_latch_R10();
      par_en  = 1'b1;
      par_sel = 2'd2;
      push(8'h00);
      par_en  = 1'b0;
      par_sel = 2'd3;
      check_frame(8'h00, 1'b1, 1'b1, "R10 latched settings");
   endtask

   task automatic t_break_idle_R9();
      brk = 1'b1;
      #1;
      check("R8 break idle txd", txd, 1'b0);
      check("R9 break blocks ready", in_ready, 1'b0);
      par_en   = 1'b0;
      in_data  = 8'h5A;
      in_valid = 1'b1;
      repeat (60) @(negedge clk);
      check("R9 still blocked", in_ready, 1'b0);
      brk = 1'b0;
      #1;
      check("R9 idle after release", in_ready, 1'b1);
      check("R9 line high after release", txd, 1'b1);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_frame(8'h5A, 1'b0, 1'b0, "R9 resumed");
   endtask

   task automatic t_break_mid_R8();
      par_en = 1'b0;
      push(8'hFF);
      wait_ticks(8);
      check("R8 start before break", txd, 1'b0);
      wait_ticks(16);
      check("R8 data bit0 high", txd, 1'b1);
      brk = 1'b1;
      #1;
      check("R8 break mid frame", txd, 1'b0);
      @(negedge clk);
      brk = 1'b0;
      #1;
      check("R8 line restored", txd, 1'b1);
      @(negedge clk);
      wait_ticks(16 * 8);
      check("R8 stop after break", txd, 1'b1);
      wait_ticks(8);
      check("R8 ready after frame", in_ready, 1'b1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frame(8'hA5, 1'b0, 2'd0, "R3 no parity");
      t_frame(8'h03, 1'b1, 2'd0, "R4 odd");
      t_frame(8'h07, 1'b1, 2'd0, "R4 odd");
      t_frame(8'h07, 1'b1, 2'd1, "R5 even");
      t_frame(8'h81, 1'b1, 2'd1, "R5 even");
      t_frame(8'h00, 1'b1, 2'd2, "R6 forced one");
      t_frame(8'hFF, 1'b1, 2'd3, "R7 forced zero");
      t_latch_R10();
      t_break_idle_R9();
      t_break_mid_R8();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule